// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block holds an eight-entry stack of opaque, fixed-width floating-point registers and the three 16-bit words that describe the stack: control, status and tag. A three-bit top pointer kept inside the status word turns each logical stack index into a physical register. All register traffic goes through that mapping. This covers pushing a new value, copying an entry onto the top, plain writes and moves between logical slots, and one-cycle exchanges.

A decoded command arrives with a valid strobe and up to two logical indices. It also carries an operand word, the result flags of an external comparison (less, equal, unordered), and a count of pops to apply once the command's own effect is done. The block updates the condition codes for compare and test-against-zero commands. It refreshes the error-summary bit before every command, and it carries out the init, clear-exceptions, control-load and flag-raise effects on the words. Arithmetic lives elsewhere. A read port returns the register at any logical index in the same cycle.

Top module: `fp_regstack`

## Requirements
- R1: A low `rst_n` at a clock edge, or command code 10 (init), sets control to 0x037F and status and tag to zero. Init ignores the pop count.
- R2: The top pointer is status bits 13:11. Command 7 and commands 1 and 2 subtract one modulo 8, and command 6 adds one modulo 8. Status bits other than 13:11 and the summary bit 15 keep their values across these commands.
- R3: Logical index i, on the read port or on an index input, selects physical register (i + top) mod 8, using the top value in force before the command.
- R4: Command 1 (push-load) moves the top down and writes `wr_data` into the new ST(0). Command 2 (push-copy) moves the top down and writes the old ST(`idx_b`) into the new ST(0). Command 3 writes `wr_data` to ST(`idx_a`), and command 4 copies ST(`idx_b`) into ST(`idx_a`).
- R5: `pop_cnt` (0 to 3) is added to the top pointer modulo 8 after the command's own pointer change, for every command except init.
- R6: Command 5 swaps ST(`idx_a`) and ST(`idx_b`) in one cycle.
- R7: Command 8 (compare) sets C0 (bit 8), C2 (bit 10) and C3 (bit 14) all to one when `cmp_unord` is high. Otherwise it clears all three, then sets C0 if `cmp_lt` is high, or else sets C3 if `cmp_eq` is high.
- R8: Command 9 (test against zero) uses `cmp_eq` as "zero", `cmp_lt` as "negative" and `cmp_unord` as "invalid". Invalid sets C0, C2 and C3. Otherwise all three are cleared, then C3 is set for zero, or else C0 is set for negative.
- R9: Before each valid command, status bit 15 becomes the OR over bits 5:0 of (control AND status), using the words in force before the command.
- R10: Command 11 (clear exceptions) leaves status ANDed with 0x7F00 (the top pointer then receives the pop count).
- R11: Command 12 loads control from `wr_data[15:0]`. Command 13 ORs `wr_data[5:0]` into status bits 5:0. Command 0 changes nothing but the summary bit and the pop count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| idx_a | input | 3 | First logical index |
| idx_b | input | 3 | Second logical index |
| pop_cnt | input | 2 | Pops applied after the command |
| wr_data | input | DATA_W | Operand word |
| cmp_lt | input | 1 | Compare result: less / negative |
| cmp_eq | input | 1 | Compare result: equal / zero |
| cmp_unord | input | 1 | Compare result: unordered / invalid |
| rd_idx | input | 3 | Logical read index |
| rd_data | output | DATA_W | Register at ST(rd_idx) |
| ctrl_word | output | 16 | Control word |
| stat_word | output | 16 | Status word |
| tag_word | output | 16 | Tag word |

## Verification
The assertions assume that `cmd_op` holds a defined code whenever `cmd_valid` is high and that `rd_idx` settles before outputs are sampled. The register-write property also assumes the bench holds `rd_idx` steady across the cycle it inspects. The bench drives every input on the falling edge and samples after the rising edge. It draws command codes only from the defined set, using a deterministic generator. Compare flags are driven in every combination, including the contradictory ones, so that the priority order of the condition codes is exercised.

// File: rtl/fpstk_pkg.sv
// Package: shared command codes and status-word field positions for the
// floating-point register stack. Assumes an 8-entry stack.
package fpstk_pkg;
    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_PUSH_LD  = 4'd1,
        OP_PUSH_CPY = 4'd2,
        OP_WRITE    = 4'd3,
        OP_MOVE     = 4'd4,
        OP_XCHG     = 4'd5,
        OP_INCP     = 4'd6,
        OP_DECP     = 4'd7,
        OP_CMP      = 4'd8,
        OP_TST      = 4'd9,
        OP_INIT     = 4'd10,
        OP_CLEX     = 4'd11,
        OP_LDCW     = 4'd12,
        OP_RAISE    = 4'd13
    } stk_op_e;

    localparam int          WORD_W    = 16;
    localparam int          TOP_LSB   = 11;
    localparam int          CC0_BIT   = 8;
    localparam int          CC2_BIT   = 10;
    localparam int          CC3_BIT   = 14;
    localparam int          SUM_BIT   = 15;
    localparam int          EXC_W     = 6;
    localparam logic [15:0] CTRL_INIT = 16'h037F;
    localparam logic [15:0] CLEX_KEEP = 16'h7F00;
endpackage

// File: rtl/fpstk_idxmap.sv
// Module: maps a logical stack index to a physical register number.
// Assumes the depth is a power of two so the wrap is a plain truncation.
module fpstk_idxmap #(
    parameter int AW = 3
) (
    input  logic [AW-1:0] top,
    input  logic [AW-1:0] lidx,
    output logic [AW-1:0] pidx
);
    // Modular add of the logical index and the top pointer.
    always_comb begin
        pidx = lidx + top;
    end
endmodule

// File: rtl/fpstk_regfile.sv
// Module: physical register array with two write ports and three
// combinational read ports. Port 1 wins when both write the same entry.
module fpstk_regfile #(
    parameter int W     = 80,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we0,
    input  logic [AW-1:0] wa0,
    input  logic [W-1:0]  wd0,
    input  logic          we1,
    input  logic [AW-1:0] wa1,
    input  logic [W-1:0]  wd1,
    input  logic [AW-1:0] ra0,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd0,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Update one entry from whichever write port targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (we1 && wa1 == AW'(g)) begin
                mem_q[g] <= wd1;
            end else if (we0 && wa0 == AW'(g)) begin
                mem_q[g] <= wd0;
            end
        end
    end

    // Combinational reads.
    always_comb begin
        rd0 = mem_q[ra0];
        rd1 = mem_q[ra1];
        rd2 = mem_q[ra2];
    end
endmodule

// File: rtl/fpstk_status.sv
// Module: control, status and tag words. Computes the summary bit, the
// condition codes, the top pointer moves and the pop count. Assumes the
// command code is defined whenever valid is high.
module fpstk_status #(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [3:0]    op,
    input  logic [1:0]    pops,
    input  logic [15:0]   data,
    input  logic          lt,
    input  logic          eq,
    input  logic          unord,
    output logic [AW-1:0] top,
    output logic [15:0]   ctrl_q,
    output logic [15:0]   stat_q,
    output logic [15:0]   tag_q
);
    import fpstk_pkg::*;

    stk_op_e       op_e;
    logic [15:0]   stat_d;
    logic [15:0]   ctrl_d;
    logic [AW-1:0] top_mid;
    logic          do_init;

    assign op_e    = stk_op_e'(op);
    assign top     = stat_q[TOP_LSB +: AW];
    assign do_init = valid && (op_e == OP_INIT);

    // Next control/status: summary first, command effect, then pops.
    always_comb begin
        stat_d          = stat_q;
        ctrl_d          = ctrl_q;
        stat_d[SUM_BIT] = |(ctrl_q[EXC_W-1:0] & stat_q[EXC_W-1:0]);
        top_mid         = top;
        case (op_e)
            OP_PUSH_LD, OP_PUSH_CPY, OP_DECP: top_mid = top - AW'(1);
            OP_INCP:  top_mid = top + AW'(1);
            OP_CMP: begin
                if (unord) begin
                    stat_d[CC0_BIT] = 1'b1;
                    stat_d[CC2_BIT] = 1'b1;
                    stat_d[CC3_BIT] = 1'b1;
                end else begin
                    stat_d[CC0_BIT] = lt;
                    stat_d[CC2_BIT] = 1'b0;
                    stat_d[CC3_BIT] = !lt && eq;
                end
            end
            OP_TST: begin
                if (unord) begin
                    stat_d[CC0_BIT] = 1'b1;
                    stat_d[CC2_BIT] = 1'b1;
                    stat_d[CC3_BIT] = 1'b1;
                end else begin
                    stat_d[CC3_BIT] = eq;
                    stat_d[CC2_BIT] = 1'b0;
                    stat_d[CC0_BIT] = !eq && lt;
                end
            end
            OP_CLEX:  stat_d = stat_d & CLEX_KEEP;
            OP_LDCW:  ctrl_d = data;
            OP_RAISE: stat_d[EXC_W-1:0] = stat_d[EXC_W-1:0] | data[EXC_W-1:0];
            default: ;
        endcase
        stat_d[TOP_LSB +: AW] = top_mid + AW'(pops);
    end

    // Word registers; reset and init share one path.
    always_ff @(posedge clk) begin
        if (!rst_n || do_init) begin
            ctrl_q <= CTRL_INIT;
            stat_q <= '0;
            tag_q  <= '0;
        end else if (valid) begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
        end
    end
endmodule

// File: rtl/fp_regstack.sv
// Module: floating-point register stack controller. Maps logical indices
// through the top pointer and drives register writes for push, write,
// move and exchange. Assumes DATA_W >= 16 and DEPTH = 8.
module fp_regstack #(
    parameter int DATA_W = 80,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [AW-1:0]     idx_a,
    input  logic [AW-1:0]     idx_b,
    input  logic [1:0]        pop_cnt,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmp_lt,
    input  logic              cmp_eq,
    input  logic              cmp_unord,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [15:0]       ctrl_word,
    output logic [15:0]       stat_word,
    output logic [15:0]       tag_word
);
    import fpstk_pkg::*;

    stk_op_e           op_e;
    logic [AW-1:0]     top;
    logic [AW-1:0]     pa, pb, pr, ppush;
    logic [DATA_W-1:0] ra_data, rb_data;
    logic              we0, we1;
    logic [AW-1:0]     wa0, wa1;
    logic [DATA_W-1:0] wd0, wd1;

    assign op_e = stk_op_e'(cmd_op);

    fpstk_idxmap #(.AW(AW)) u_map_a (.top(top), .lidx(idx_a),  .pidx(pa));
    fpstk_idxmap #(.AW(AW)) u_map_b (.top(top), .lidx(idx_b),  .pidx(pb));
    fpstk_idxmap #(.AW(AW)) u_map_r (.top(top), .lidx(rd_idx), .pidx(pr));
    // Logical DEPTH-1 under the current top is ST(0) after a push.
    fpstk_idxmap #(.AW(AW)) u_map_p (.top(top), .lidx({AW{1'b1}}), .pidx(ppush));

    // Register write steering per command.
    always_comb begin
        we0 = 1'b0;
        wa0 = pa;
        wd0 = wr_data;
        we1 = 1'b0;
        wa1 = pb;
        wd1 = ra_data;
        if (cmd_valid) begin
            case (op_e)
                OP_PUSH_LD: begin
                    we0 = 1'b1;
                    wa0 = ppush;
                end
                OP_PUSH_CPY: begin
                    we0 = 1'b1;
                    wa0 = ppush;
                    wd0 = rb_data;
                end
                OP_WRITE: we0 = 1'b1;
                OP_MOVE: begin
                    we0 = 1'b1;
                    wd0 = rb_data;
                end
                OP_XCHG: begin
                    we0 = 1'b1;
                    wd0 = rb_data;
                    we1 = 1'b1;
                end
                default: ;
            endcase
        end
    end

    fpstk_regfile #(.W(DATA_W), .DEPTH(DEPTH)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we0(we0), .wa0(wa0), .wd0(wd0),
        .we1(we1), .wa1(wa1), .wd1(wd1),
        .ra0(pa), .ra1(pb), .ra2(pr),
        .rd0(ra_data), .rd1(rb_data), .rd2(rd_data)
    );

    fpstk_status #(.DEPTH(DEPTH)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .valid(cmd_valid), .op(cmd_op), .pops(pop_cnt),
        .data(wr_data[15:0]),
        .lt(cmp_lt), .eq(cmp_eq), .unord(cmp_unord),
        .top(top),
        .ctrl_q(ctrl_word), .stat_q(stat_word), .tag_q(tag_word)
    );
endmodule

// File: rtl/fp_regstack_chk.sv
// Checker: temporal properties of the register stack, bound to the top.
module fp_regstack_chk #(
    parameter int DATA_W = 80,
    parameter int AW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic [1:0]        pop_cnt,
    input logic [DATA_W-1:0] wr_data,
    input logic              cmp_unord,
    input logic [AW-1:0]     rd_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic [15:0]       ctrl_word,
    input logic [15:0]       stat_word,
    input logic [15:0]       tag_word
);
    p_init_words_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd10) |=>
            (ctrl_word == 16'h037F && stat_word == 16'h0 && tag_word == 16'h0));

    p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd7 && pop_cnt == 2'd0) |=>
            (stat_word[13:11] == $past(stat_word[13:11]) - 3'd1));

    p_pop_keeps_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd6) |=>
            (stat_word[14] == $past(stat_word[14]) &&
             stat_word[10:0] == $past(stat_word[10:0])));

    p_push_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd1 && pop_cnt == 2'd0 && rd_idx == '0) |=>
            (rd_idx != '0 || rd_data == $past(wr_data)));

    p_unord_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd8 && cmp_unord) |=>
            (stat_word[8] && stat_word[10] && stat_word[14]));

    p_clex_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd11) |=>
            (stat_word[15] == 1'b0 && stat_word[7:0] == 8'h0));
endmodule

bind fp_regstack fp_regstack_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pop_cnt(pop_cnt), .wr_data(wr_data), .cmp_unord(cmp_unord),
    .rd_idx(rd_idx), .rd_data(rd_data), .ctrl_word(ctrl_word),
    .stat_word(stat_word), .tag_word(tag_word)
);

// File: tb/fp_regstack_tb_top.sv
`timescale 1ns/100ps
// Bench: directed and generated command streams against an arithmetic
// model of the stack; every step checks the three words and all eight
// logical registers.
module fp_regstack_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [3:0]   cmd_op = '0;
    logic [2:0]   idx_a = '0, idx_b = '0, rd_idx = '0;
    logic [1:0]   pop_cnt = '0;
    logic [W-1:0] wr_data = '0;
    logic         cmp_lt = 1'b0, cmp_eq = 1'b0, cmp_unord = 1'b0;
    logic [W-1:0] rd_data;
    logic [15:0]  ctrl_word, stat_word, tag_word;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] ref_reg [8];
    logic [15:0]  ref_ctrl, ref_stat;
    int unsigned  lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    fp_regstack #(.DATA_W(W), .DEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .idx_a(idx_a), .idx_b(idx_b), .pop_cnt(pop_cnt), .wr_data(wr_data),
        .cmp_lt(cmp_lt), .cmp_eq(cmp_eq), .cmp_unord(cmp_unord),
        .rd_idx(rd_idx), .rd_data(rd_data), .ctrl_word(ctrl_word),
        .stat_word(stat_word), .tag_word(tag_word)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_init();
        ref_ctrl = 16'h037F;
        ref_stat = 16'h0000;
    endtask

    function automatic string req_of(input int op);
        case (op)
            1, 2, 3, 4: return "R4";
            5:          return "R6";
            6, 7:       return "R2";
            8:          return "R7";
            9:          return "R8";
            10:         return "R1";
            11:         return "R10";
            default:    return "R11";
        endcase
    endfunction

    task automatic model(input int op, input int a, input int b, input logic [W-1:0] d,
                         input bit lt, input bit eq, input bit un, input int pops);
        logic [15:0] s;
        logic [W-1:0] tmp;
        int t, nt, pa, pb, pp;
        if (op == 10) begin
            model_init();
            return;
        end
        s = ref_stat;
        s[15] = |(ref_ctrl[5:0] & ref_stat[5:0]);
        t = int'(s[13:11]);
        pa = (a + t) % 8;
        pb = (b + t) % 8;
        pp = (t + 7) % 8;
        nt = t;
        case (op)
            1: begin ref_reg[pp] = d; nt = pp; end
            2: begin ref_reg[pp] = ref_reg[pb]; nt = pp; end
            3: ref_reg[pa] = d;
            4: ref_reg[pa] = ref_reg[pb];
            5: begin tmp = ref_reg[pa]; ref_reg[pa] = ref_reg[pb]; ref_reg[pb] = tmp; end
            6: nt = (t + 1) % 8;
            7: nt = pp;
            8: begin
                if (un) begin s[8] = 1; s[10] = 1; s[14] = 1; end
                else begin s[8] = lt; s[10] = 0; s[14] = !lt && eq; end
            end
            9: begin
                if (un) begin s[8] = 1; s[10] = 1; s[14] = 1; end
                else begin s[14] = eq; s[10] = 0; s[8] = !eq && lt; end
            end
            11: s = s & 16'h7F00;
            12: ref_ctrl = d[15:0];
            13: s[5:0] = s[5:0] | d[5:0];
            default: ;
        endcase
        nt = (nt + pops) % 8;
        s[13:11] = 3'(nt);
        ref_stat = s;
    endtask

    // Compare words and all eight logical reads (R3 mapping).
    task automatic check_all(input string req);
        int t;
        chk({req, " ctrl"}, W'(ctrl_word), W'(ref_ctrl));
        chk({req, " stat"}, W'(stat_word), W'(ref_stat));
        chk("R1 tag", W'(tag_word), '0);
        t = int'(ref_stat[13:11]);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.4;
            chk({req, "/R3 read"}, rd_data, ref_reg[(i + t) % 8]);
        end
        rd_idx = '0;
    endtask

    task automatic issue(input int op, input int a, input int b, input logic [W-1:0] d,
                         input bit lt, input bit eq, input bit un, input int pops);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = 4'(op);
        idx_a = 3'(a);
        idx_b = 3'(b);
        wr_data = d;
        cmp_lt = lt;
        cmp_eq = eq;
        cmp_unord = un;
        pop_cnt = 2'(pops);
        rd_idx = '0;
        @(posedge clk);
        model(op, a, b, d, lt, eq, un, pops);
        #1;
        cmd_valid = 1'b0;
        check_all(pops != 0 ? "R5" : req_of(op));
    endtask

    function automatic int unsigned nxt();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg >> 8;
    endfunction

    initial begin
        #(8ns * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) ref_reg[i] = '0;
        model_init();
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R4: fill all slots by push-load, then every top position.
        for (int i = 0; i < 8; i++) issue(1, 0, 0, W'(16'hA000 + i), 0, 0, 0, 0);
        for (int t = 0; t < 8; t++) begin
            issue(7, 0, 0, '0, 0, 0, 0, 0);  // R2 push pointer
            for (int i = 0; i < 8; i++) issue(3, i, 0, W'(t * 16 + i), 0, 0, 0, 0);
        end
        for (int t = 0; t < 9; t++) issue(6, 0, 0, '0, 0, 0, 0, 0);  // R2 pop wrap
        // R6: exchange every pair, R4 move and push-copy.
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) issue(5, a, b, '0, 0, 0, 0, 0);
        for (int b = 0; b < 8; b++) issue(4, (b + 3) % 8, b, '0, 0, 0, 0, 0);
        for (int b = 0; b < 8; b++) issue(2, 0, b, '0, 0, 0, 0, b % 4);
        // R7/R8: every flag combination.
        for (int f = 0; f < 8; f++) begin
            issue(8, 0, 0, '0, f[0], f[1], f[2], 0);
            issue(9, 0, 0, '0, f[0], f[1], f[2], 0);
        end
        // R9/R11/R10: mask and flag sweep for the summary bit.
        for (int m = 0; m < 64; m += 7) begin
            issue(12, 0, 0, W'(16'h0300 | m), 0, 0, 0, 0);
            issue(13, 0, 0, W'(m ^ 6'h15), 0, 0, 0, 0);
            issue(0, 0, 0, '0, 0, 0, 0, 0);
            issue(0, 0, 0, '0, 0, 0, 0, 1);
            issue(11, 0, 0, '0, 0, 0, 0, 0);
        end
        issue(10, 0, 0, '0, 0, 0, 0, 3);  // R1 init ignores pops
        // Generated stream over all commands.
        for (int k = 0; k < 1500; k++) begin
            int unsigned r;
            int op;
            r = nxt();
            op = int'(r % 14);
            if (op == 10 && (r & 32'h300) != 0) op = 0;
            issue(op, int'((r >> 4) & 7), int'((r >> 7) & 7), W'(nxt()),
                  r[12], r[13], r[14] & r[15], int'((r >> 16) & 3));
        end
        // R1: reset mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 8; i++) ref_reg[i] = '0;
        model_init();
        #1;
        check_all("R1 reset");
        rst_n = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule